// File: doc/BRIEF.md
# Soft-Symbol Depuncturer with Run-Time Pattern Loading

The block sits at the input of a rate-1/2 convolutional decoder. It takes a stream of received soft symbols from a punctured code, one symbol per clock, and rebuilds the full branch pairs that the decoder expects. Wherever puncturing removed a symbol, the block inserts a zero soft value and raises that symbol's erasure flag. A strobe on the first symbol of each puncture block restarts the pattern, so the depuncturing phase stays locked to the transmitter.

The code rate and the two puncture patterns (pattern A feeds branch 0 and pattern B feeds branch 1) come from input ports. They are captured by a set strobe into a shadow copy that is checked for legality. A legal copy becomes active at the next block-start strobe. An illegal one is discarded and a sticky error flag is raised. Until a legal setting has been made active, the block produces nothing.

Each block of N received symbols yields K output pairs. The output valid therefore drops N−K times per block, in the cycles where the first half of a fully kept column is being held.

Top module: `depuncturer`

## Requirements
- R1: While reset is applied and right after it, out_valid, cfg_ok and cfg_err are all low.
- R2: Column c uses bit c of each pattern (LSB is column 0). A bit of 1 places one received symbol in that branch. A bit of 0 produces the soft value 0 with the branch's erasure flag set to 1. A pair never has both flags set.
- R3: In a column where both bits are 1, the first symbol goes to branch 0 and the second to branch 1. No pair is produced for the first symbol. The pair appears one cycle after the second symbol. In a column with a single 1, the pair appears one cycle after its symbol.
- R4: A block-start strobe makes its own symbol the first symbol of column 0 and discards any held half pair.
- R5: After column K−1 the pattern wraps to column 0 without a strobe, so the output continues with an unbroken input stream.
- R6: A setting is legal only if 1 ≤ K ≤ MAX_IN and either K = 1 with N = 2, or K < N < 2K.
- R7: A setting is also legal only if the pattern bits below position K hold exactly N ones and every column below K has at least one 1. Pattern bits at K and above are ignored.
- R8: Rate and pattern inputs are read only when set_stb is high. An illegal setting leaves both the active and the waiting setting unchanged, and sets cfg_err, which stays high until reset.
- R9: A legal setting takes effect at the first block-start strobe in a later cycle than its set_stb. A strobe in the same cycle still uses the earlier setting.
- R10: Until a legal setting has become active, out_valid stays low. cfg_ok rises in the cycle after the strobe that activates the first legal setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_sym | input | SW | Received soft symbol, one per cycle |
| blk_start | input | 1 | High with the first symbol of a puncture block |
| set_stb | input | 1 | Capture the rate and pattern inputs this cycle |
| set_k | input | KW | Information bits per block (K) |
| set_n | input | NW | Transmitted symbols per block (N) |
| set_pat_a | input | MAX_IN | Keep pattern for branch 0, column c in bit c |
| set_pat_b | input | MAX_IN | Keep pattern for branch 1, column c in bit c |
| out_valid | output | 1 | Restored pair present |
| out_sym0 | output | SW | Branch 0 soft value |
| out_sym1 | output | SW | Branch 1 soft value |
| out_era0 | output | 1 | Branch 0 was punctured |
| out_era1 | output | 1 | Branch 1 was punctured |
| cfg_ok | output | 1 | An active legal setting exists |
| cfg_err | output | 1 | Sticky: an illegal setting was rejected |

## Verification
Each restored pair is due one clock edge after the symbol that completes its column. cfg_ok and cfg_err change one edge after the strobe that causes them. The bench drives one input set per cycle on the falling edge and advances its reference model for that input. It then compares every output on the next falling edge, which is exactly one register stage later, so gaps, data and flags are all checked at their due cycle. Setting changes are placed before, on and after block-start strobes, which pins down the cycle in which a new pattern first shapes the output.

// File: rtl/depunct_pkg.sv
// Package: shared encodings for the depuncturer.
// Assumes: nothing beyond SystemVerilog 2017.
package depunct_pkg;

    // Kept-symbol content of one pattern column: {pattern B bit, pattern A bit}
    typedef enum logic [1:0] {
        COL_NONE = 2'b00,
        COL_A    = 2'b01,
        COL_B    = 2'b10,
        COL_AB   = 2'b11
    } col_kind_e;

endpackage

// File: rtl/dp_cfg_check.sv
// Module: dp_cfg_check
// Purpose: combinational legality test of one rate/pattern setting.
// Assumes: pattern bits at or above k are don't-care; every column below k
// must keep at least one symbol.
module dp_cfg_check #(
    parameter int MAX_IN = 8,
    parameter int KW     = 4,
    parameter int NW     = 5
) (
    input  logic [KW-1:0]     k,
    input  logic [NW-1:0]     n,
    input  logic [MAX_IN-1:0] pat_a,
    input  logic [MAX_IN-1:0] pat_b,
    output logic              legal
);

    int  ones;
    logic hole;
    int  ki;
    int  ni;
    logic rate_ok;

    // Count kept bits below k and look for columns with nothing kept
    always_comb begin
        ones = 0;
        hole = 1'b0;
        ki   = int'(k);
        ni   = int'(n);
        for (int i = 0; i < MAX_IN; i++) begin
            if (i < ki) begin
                ones = ones + int'(pat_a[i]) + int'(pat_b[i]);
                if (!(pat_a[i] || pat_b[i])) hole = 1'b1;
            end
        end
    end

    // Rate relation between k and n
    always_comb begin
        if (ki < 1 || ki > MAX_IN)  rate_ok = 1'b0;
        else if (ki == 1)           rate_ok = (ni == 2);
        else                        rate_ok = (ni > ki) && (ni < 2 * ki);
    end

    // Final verdict
    always_comb begin
        legal = rate_ok && !hole && (ones == ni);
    end

endmodule

// File: rtl/dp_cfg_regs.sv
// Module: dp_cfg_regs
// Purpose: shadow (waiting) and active setting registers plus the sticky error.
// Assumes: 'legal' is the verdict on the set_* inputs in the same cycle;
// 'promote' is high only when a waiting setting exists and a block starts.
module dp_cfg_regs #(
    parameter int MAX_IN = 8,
    parameter int KW     = 4,
    parameter int NW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_stb,
    input  logic [KW-1:0]     set_k,
    input  logic [MAX_IN-1:0] set_pat_a,
    input  logic [MAX_IN-1:0] set_pat_b,
    input  logic              legal,
    input  logic              promote,
    output logic              pend_v,
    output logic [KW-1:0]     pend_k,
    output logic [MAX_IN-1:0] pend_a,
    output logic [MAX_IN-1:0] pend_b,
    output logic              act_v,
    output logic [KW-1:0]     act_k,
    output logic [MAX_IN-1:0] act_a,
    output logic [MAX_IN-1:0] act_b,
    output logic              err
);

    logic take;

    // A capture happens only for a legal setting under the strobe
    always_comb take = set_stb && legal;

    // Shadow setting: loaded on a legal capture, released on promotion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v <= 1'b0;
            pend_k <= '0;
            pend_a <= '0;
            pend_b <= '0;
        end else if (take) begin
            pend_v <= 1'b1;
            pend_k <= set_k;
            pend_a <= set_pat_a;
            pend_b <= set_pat_b;
        end else if (promote) begin
            pend_v <= 1'b0;
        end
    end

    // Active setting: copied from the shadow at a block start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_v <= 1'b0;
            act_k <= '0;
            act_a <= '0;
            act_b <= '0;
        end else if (promote) begin
            act_v <= 1'b1;
            act_k <= pend_k;
            act_a <= pend_a;
            act_b <= pend_b;
        end
    end

    // Sticky rejection flag
    always_ff @(posedge clk) begin
        if (!rst_n)                    err <= 1'b0;
        else if (set_stb && !legal)    err <= 1'b1;
    end

    // R8
    reject_keeps_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb && !legal |=> $stable(pend_k) && $stable(pend_a) && $stable(pend_b));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R9
    active_moves_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !promote |=> $stable(act_a) && $stable(act_b) && $stable(act_k));

endmodule

// File: rtl/dp_phase.sv
// Module: dp_phase
// Purpose: walks the pattern columns, holds the first half of fully kept
// columns, and emits registered branch pairs with erasure flags.
// Assumes: k/pat_a/pat_b are the setting in force this cycle and describe a
// legal setting whenever 'run' is high.
module dp_phase
    import depunct_pkg::*;
#(
    parameter int MAX_IN = 8,
    parameter int SW     = 3,
    parameter int KW     = 4,
    localparam int CW    = (MAX_IN > 1) ? $clog2(MAX_IN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              start,
    input  logic [KW-1:0]     k,
    input  logic [MAX_IN-1:0] pat_a,
    input  logic [MAX_IN-1:0] pat_b,
    input  logic [SW-1:0]     sym,
    output logic              o_valid,
    output logic [SW-1:0]     o_sym0,
    output logic [SW-1:0]     o_sym1,
    output logic              o_era0,
    output logic              o_era1
);

    logic [CW-1:0] col_q, col_n, cur_col;
    logic          half_q, half_n, cur_half;
    logic [SW-1:0] hold_q, hold_n;
    col_kind_e     kind;
    logic          last, adv;
    logic          v_n, e0_n, e1_n;
    logic [SW-1:0] s0_n, s1_n;

    // Column and half position seen by this cycle's symbol
    always_comb begin
        cur_col  = start ? '0 : col_q;
        cur_half = start ? 1'b0 : half_q;
        kind     = col_kind_e'({pat_b[cur_col], pat_a[cur_col]});
        last     = (KW'(cur_col) + KW'(1)) >= k;
    end

    // Decide this cycle's output and the next position
    always_comb begin
        v_n    = 1'b0;
        s0_n   = '0;
        s1_n   = '0;
        e0_n   = 1'b0;
        e1_n   = 1'b0;
        adv    = 1'b0;
        half_n = 1'b0;
        hold_n = hold_q;
        if (run) begin
            unique case (kind)
                COL_AB: begin
                    if (!cur_half) begin
                        hold_n = sym;
                        half_n = 1'b1;
                    end else begin
                        v_n  = 1'b1;
                        s0_n = hold_q;
                        s1_n = sym;
                        adv  = 1'b1;
                    end
                end
                COL_A: begin
                    v_n  = 1'b1;
                    s0_n = sym;
                    e1_n = 1'b1;
                    adv  = 1'b1;
                end
                COL_B: begin
                    v_n  = 1'b1;
                    s1_n = sym;
                    e0_n = 1'b1;
                    adv  = 1'b1;
                end
                default: adv = 1'b1;
            endcase
        end
        if (!run)      col_n = '0;
        else if (adv)  col_n = last ? '0 : cur_col + CW'(1);
        else           col_n = cur_col;
    end

    // Position state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q  <= '0;
            half_q <= 1'b0;
            hold_q <= '0;
        end else begin
            col_q  <= col_n;
            half_q <= half_n;
            hold_q <= hold_n;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_sym0  <= '0;
            o_sym1  <= '0;
            o_era0  <= 1'b0;
            o_era1  <= 1'b0;
        end else begin
            o_valid <= v_n;
            o_sym0  <= s0_n;
            o_sym1  <= s1_n;
            o_era0  <= e0_n;
            o_era1  <= e1_n;
        end
    end

    // R2
    one_erasure_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |-> !(o_era0 && o_era1));

    // R2
    erased_is_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid && (o_era0 || o_era1) |-> (o_era0 ? o_sym0 == '0 : o_sym1 == '0));

    // R3
    half_only_in_pair_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_q && !start |-> pat_a[col_q] && pat_b[col_q]);

    // R3
    gap_after_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_q |-> !o_valid);

endmodule

// File: rtl/depuncturer.sv
// Module: depuncturer (top)
// Purpose: rebuilds rate-1/2 soft-symbol pairs from a punctured stream using
// run-time loaded, legality-checked patterns applied at block starts.
// Assumes: one input symbol per clock; blk_start marks the first symbol of
// each block.
module depuncturer #(
    parameter int MAX_IN = 8,
    parameter int SW     = 3,
    localparam int KW    = $clog2(MAX_IN + 1),
    localparam int NW    = $clog2(2 * MAX_IN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SW-1:0]     in_sym,
    input  logic              blk_start,
    input  logic              set_stb,
    input  logic [KW-1:0]     set_k,
    input  logic [NW-1:0]     set_n,
    input  logic [MAX_IN-1:0] set_pat_a,
    input  logic [MAX_IN-1:0] set_pat_b,
    output logic              out_valid,
    output logic [SW-1:0]     out_sym0,
    output logic [SW-1:0]     out_sym1,
    output logic              out_era0,
    output logic              out_era1,
    output logic              cfg_ok,
    output logic              cfg_err
);

    logic              legal, promote;
    logic              pend_v, act_v;
    logic [KW-1:0]     pend_k, act_k, eff_k;
    logic [MAX_IN-1:0] pend_a, pend_b, act_a, act_b, eff_a, eff_b;
    logic              eff_v;

    dp_cfg_check #(.MAX_IN(MAX_IN), .KW(KW), .NW(NW)) u_check (
        .k     (set_k),
        .n     (set_n),
        .pat_a (set_pat_a),
        .pat_b (set_pat_b),
        .legal (legal)
    );

    // A waiting setting replaces the active one when a block starts
    always_comb promote = blk_start && pend_v;

    dp_cfg_regs #(.MAX_IN(MAX_IN), .KW(KW), .NW(NW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_stb   (set_stb),
        .set_k     (set_k),
        .set_pat_a (set_pat_a),
        .set_pat_b (set_pat_b),
        .legal     (legal),
        .promote   (promote),
        .pend_v    (pend_v),
        .pend_k    (pend_k),
        .pend_a    (pend_a),
        .pend_b    (pend_b),
        .act_v     (act_v),
        .act_k     (act_k),
        .act_a     (act_a),
        .act_b     (act_b),
        .err       (cfg_err)
    );

    // Setting in force for this cycle's symbol
    always_comb begin
        eff_v = promote ? 1'b1   : act_v;
        eff_k = promote ? pend_k : act_k;
        eff_a = promote ? pend_a : act_a;
        eff_b = promote ? pend_b : act_b;
    end

    dp_phase #(.MAX_IN(MAX_IN), .SW(SW), .KW(KW)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (eff_v),
        .start   (blk_start),
        .k       (eff_k),
        .pat_a   (eff_a),
        .pat_b   (eff_b),
        .sym     (in_sym),
        .o_valid (out_valid),
        .o_sym0  (out_sym0),
        .o_sym1  (out_sym1),
        .o_era0  (out_era0),
        .o_era1  (out_era1)
    );

    // Report whether a legal setting is in force
    always_comb cfg_ok = act_v;

    // R10
    no_output_without_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> cfg_ok);

    // R10
    cfg_ok_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ok |=> cfg_ok);

endmodule

// File: tb/sim_depuncturer.sv
module sim_depuncturer;

    localparam int MAX_IN = 8;
    localparam int SW     = 3;
    localparam int KW     = $clog2(MAX_IN + 1);
    localparam int NW     = $clog2(2 * MAX_IN + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [SW-1:0]     in_sym = '0;
    logic              blk_start = 1'b0;
    logic              set_stb = 1'b0;
    logic [KW-1:0]     set_k = '0;
    logic [NW-1:0]     set_n = '0;
    logic [MAX_IN-1:0] set_pat_a = '0;
    logic [MAX_IN-1:0] set_pat_b = '0;
    logic              out_valid, out_era0, out_era1, cfg_ok, cfg_err;
    logic [SW-1:0]     out_sym0, out_sym1;

    depuncturer #(.MAX_IN(MAX_IN), .SW(SW)) u0 (.*);

    always #10 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;

    // reference model state
    bit       m_av = 0, m_pv = 0, m_err = 0, m_half = 0;
    int       m_k = 0, m_n = 0, m_pk = 0, m_pn = 0, m_col = 0;
    bit [7:0] m_a = 0, m_b = 0, m_pa = 0, m_pb = 0;
    bit [2:0] m_hold = 0;

    task automatic check(string tag, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit legal_ref(int k, int n, bit [7:0] a, bit [7:0] b);
        int cnt = 0;
        if (k < 1 || k > MAX_IN) return 0;
        for (int i = 0; i < k; i++) begin
            if (!a[i] && !b[i]) return 0;
            cnt += int'(a[i]) + int'(b[i]);
        end
        if (cnt != n) return 0;
        if (k == 1) return n == 2;
        return (n > k) && (n < 2 * k);
    endfunction

    // one clock: drive inputs, advance the model, check outputs one edge later
    task automatic cyc(bit [2:0] s, bit st, bit se, int k, int n,
                       bit [7:0] a, bit [7:0] b, string tag);
        bit ev = 0, e0 = 0, e1 = 0;
        bit [2:0] s0 = 0, s1 = 0;
        int col;
        in_sym = s; blk_start = st; set_stb = se;
        set_k = KW'(k); set_n = NW'(n); set_pat_a = a; set_pat_b = b;
        if (st && m_pv) begin
            m_av = 1; m_k = m_pk; m_n = m_pn; m_a = m_pa; m_b = m_pb; m_pv = 0;
        end
        if (m_av) begin
            bit adv = 0;
            col = st ? 0 : m_col;
            if (st) m_half = 0;
            if (m_a[col] && m_b[col]) begin
                if (!m_half) begin m_hold = s; m_half = 1; end
                else begin ev = 1; s0 = m_hold; s1 = s; m_half = 0; adv = 1; end
            end else if (m_a[col]) begin
                ev = 1; s0 = s; e1 = 1; adv = 1;
            end else begin
                ev = 1; s1 = s; e0 = 1; adv = 1;
            end
            m_col = adv ? ((col == m_k - 1) ? 0 : col + 1) : col;
        end
        if (se) begin
            if (legal_ref(k, n, a, b)) begin
                m_pv = 1; m_pk = k; m_pn = n; m_pa = a; m_pb = b;
            end else m_err = 1;
        end
        @(posedge clk);
        @(negedge clk);
        blk_start = 0; set_stb = 0;
        check(tag, "out_valid", int'(out_valid), int'(ev));
        if (ev) begin
            check(tag, "out_sym0", int'(out_sym0), int'(s0));
            check(tag, "out_sym1", int'(out_sym1), int'(s1));
            check(tag, "out_era0", int'(out_era0), int'(e0));
            check(tag, "out_era1", int'(out_era1), int'(e1));
        end
        check("R10", "cfg_ok", int'(cfg_ok), int'(m_av));
        check("R8", "cfg_err", int'(cfg_err), int'(m_err));
    endtask

    task automatic sym_cyc(bit st, string tag);
        cyc(3'($urandom), st, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic block(string tag);
        for (int i = 0; i < m_n; i++) sym_cyc(i == 0, tag);
    endtask

    task automatic gen_cfg(output int k, output int n, output bit [7:0] a, output bit [7:0] b);
        int dbl = 0;
        k = $urandom_range(1, MAX_IN);
        n = (k == 1) ? 2 : $urandom_range(k + 1, 2 * k - 1);
        a = 0; b = 0;
        for (int i = 0; i < k; i++)
            if ($urandom_range(0, 1) == 1) a[i] = 1; else b[i] = 1;
        while (dbl < n - k) begin
            int c = $urandom_range(0, k - 1);
            if (!(a[c] && b[c])) begin a[c] = 1; b[c] = 1; dbl++; end
        end
        // R7: junk above column k-1 must not matter
        if (k < 8) begin
            a = a | (8'($urandom) << k);
            b = b | (8'($urandom) << k);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int k, n;
        bit [7:0] a, b;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1", "out_valid", int'(out_valid), 0);
        check("R1", "cfg_ok", int'(cfg_ok), 0);
        check("R1", "cfg_err", int'(cfg_err), 0);
        rst_n = 1;

        // R10: blocks before any load produce nothing
        for (int i = 0; i < 6; i++) sym_cyc(i % 3 == 0, "R10");
        // legal rate 1/2 set, no start yet: still nothing
        cyc(3'd5, 0, 1, 1, 2, 8'h01, 8'h01, "R10");
        sym_cyc(0, "R10");
        sym_cyc(0, "R10");
        // activated by the start strobe
        m_n = 2;
        block("R3");
        block("R3");

        // R6: rate relation violated; R7: ones count wrong; bad k
        cyc(3'd1, 0, 1, 3, 6, 8'h07, 8'h07, "R6");
        cyc(3'd2, 0, 1, 1, 3, 8'h01, 8'h01, "R6");
        cyc(3'd3, 0, 1, 9, 10, 8'hFF, 8'h03, "R6");
        cyc(3'd4, 0, 1, 2, 3, 8'h03, 8'h03, "R7");
        cyc(3'd6, 0, 1, 3, 4, 8'h03, 8'h03, "R7");
        // R8: active setting still rate 1/2 after rejections
        block("R8");
        block("R8");

        // R9: set with a start in the same cycle: old pattern used for this block
        cyc(3'd7, 1, 1, 2, 3, 8'h03, 8'h02, "R9");
        sym_cyc(0, "R9");
        // next start activates 2/3
        m_n = 3;
        block("R9");
        // R5: continuous stream without strobes wraps the pattern
        for (int i = 0; i < 9; i++) sym_cyc(0, "R5");
        // R2: branch B only column patterns: 3/4 with A=101, B=110
        cyc(3'd2, 0, 1, 3, 4, 8'h05, 8'h06, "R2");
        sym_cyc(0, "R2");
        sym_cyc(0, "R2");
        m_n = 4;
        block("R2");
        block("R2");
        // R4: resync with a half pair held (column 0 is A=1,B=1 in 2/3 of A=01,B=11)
        cyc(3'd1, 0, 1, 2, 3, 8'h01, 8'h03, "R4");
        sym_cyc(1, "R4");
        sym_cyc(1, "R4");
        sym_cyc(0, "R4");
        sym_cyc(0, "R4");
        sym_cyc(1, "R4");
        sym_cyc(0, "R4");
        sym_cyc(1, "R4");
        m_n = 3;
        block("R4");

        // constrained random mix
        for (int t = 0; t < 150; t++) begin
            int len;
            gen_cfg(k, n, a, b);
            if ($urandom_range(0, 5) == 0) n = n + 1;
            len = m_n;
            for (int i = 0; i < len; i++) begin
                bit st = (i == 0);
                bit se = (i == len / 2) || (st && $urandom_range(0, 3) == 0);
                if ($urandom_range(0, 19) == 0 && i > 0) st = 1;
                cyc(3'($urandom), st, se, k, n, a, b, "R2");
            end
            for (int r = 0; r < 2; r++) block("R3");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule